// File: doc/BRIEF.md
# Board Status and Soft-Reset Register Block

This block answers a simple memory-mapped register bus with a set of 32-bit words describing the board it sits on: memory lock and calibration state, clock-divider settings, build options, and memory size and speed. Every status word is either a constant or is packed from elaboration parameters. The block holds no writable storage of its own; the clock generator, memory controller and reset sequencer it describes live elsewhere.

One register triggers an action. A full-word write to the soft-reset offset with bit 4 set produces a single-cycle system reset request. The block only honours 4-byte accesses. Any other access size, and any offset the block does not implement, returns zero and raises a one-cycle unsupported-access flag. Apart from that flag, such an access has no effect.

Top module: `sysinfo_regs`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `bus_rdata`, `bad_access` and `sys_reset_req` are all zero.
- R2: Read data appears on `bus_rdata` in the cycle after the one in which `bus_rd` was sampled. In every cycle that does not follow a read, `bus_rdata` is zero.
- R3: Only `bus_addr[15:0]` selects a register, so any value of the higher address bits gives the same result.
- R4: Offsets 0x0000 (build identifier), 0x0004 and 0x0008 (two change-list identifiers) read as zero and do not raise `bad_access`.
- R5: Offset 0x0014 (memory status) reads 0x00000005: bit 0 is locked and bit 2 is calibrated.
- R6: Offset 0x0030 (clock divider) reads clock-0 divide = 1 in [7:0], INPUT_MHZ in [15:8], multiplier = 1 in [23:16] and clock-1 divide = 1 in [31:24].
- R7: Offset 0x0034 (build options) reads 0x0000000E: the three link enables in bits 3:1 are set and the coherency-unit enable in bit 0 is clear.
- R8: Offset 0x0038 (memory configuration) reads MEM_GIB in [3:0] and 0xFFF in the speed field [15:4], with bits [31:16] zero.
- R9: A 4-byte write to offset 0x0010 with `bus_wdata[4]` = 1 drives `sys_reset_req` high for exactly the next cycle. The same write with bit 4 clear drives no request.
- R10: An access with `bus_size` other than 4 reads zero, is ignored on a write (even to 0x0010 with bit 4 set), and pulses `bad_access` in the next cycle.
- R11: A 4-byte read of any offset outside {0x00, 0x04, 0x08, 0x14, 0x30, 0x34, 0x38} returns zero and pulses `bad_access` in the next cycle.
- R12: A 4-byte write to one of the fixed registers or to 0x0018 has no effect and raises no flag. A 4-byte write to any offset outside {0x00, 0x04, 0x08, 0x10, 0x14, 0x18, 0x30, 0x34, 0x38} pulses `bad_access` and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; only bits 15:0 are decoded |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, zero when idle |
| bad_access | output | 1 | One-cycle flag for a wrong size or an unknown offset |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with INPUT_MHZ = 50 and MEM_GIB = 2 instead of the defaults of 100 and 1. A packing error in the divider word or the memory-configuration word therefore shows up as a wrong value rather than a coincidental match. Because the non-default values reach both fields, the check also shows that the parameters propagate through the value module. Upper address bits are set to non-zero patterns on both a read and a reset write, which confirms that only the low half of the address is decoded.

// File: rtl/sysinfo_pkg.sv
// Shared offsets and register identifiers for the board status block.
// Assumes word-aligned 16-bit offsets; the soft-reset trigger bit is fixed.
package sysinfo_pkg;

    localparam int OFF_W   = 16;
    localparam int DATA_W  = 32;
    localparam int FULL_SZ = 4;
    localparam int RST_BIT = 4;

    localparam logic [OFF_W-1:0] OFF_BUILD_ID  = 16'h0000;
    localparam logic [OFF_W-1:0] OFF_CHG_A     = 16'h0004;
    localparam logic [OFF_W-1:0] OFF_CHG_B     = 16'h0008;
    localparam logic [OFF_W-1:0] OFF_SOFT_RST  = 16'h0010;
    localparam logic [OFF_W-1:0] OFF_MEM_STAT  = 16'h0014;
    localparam logic [OFF_W-1:0] OFF_LINK_STAT = 16'h0018;
    localparam logic [OFF_W-1:0] OFF_CLK_DIV   = 16'h0030;
    localparam logic [OFF_W-1:0] OFF_BUILD_OPT = 16'h0034;
    localparam logic [OFF_W-1:0] OFF_MEM_CFG   = 16'h0038;

    typedef enum logic [3:0] {
        RID_NONE,
        RID_BUILD_ID,
        RID_CHG_A,
        RID_CHG_B,
        RID_SOFT_RST,
        RID_MEM_STAT,
        RID_LINK_STAT,
        RID_CLK_DIV,
        RID_BUILD_OPT,
        RID_MEM_CFG
    } reg_id_e;

endpackage

// File: rtl/sysinfo_decode.sv
// Offset decoder: maps a 16-bit offset to a register identifier and tells
// whether a full-word read or write to it is a supported access.
// Assumes the caller has already stripped the upper address bits.
module sysinfo_decode
    import sysinfo_pkg::*;
(
    input  logic [OFF_W-1:0] offset,
    output reg_id_e          reg_id,
    output logic             rd_known,
    output logic             wr_known
);

    // Match the offset against the implemented register list.
    always_comb begin
        case (offset)
            OFF_BUILD_ID:  reg_id = RID_BUILD_ID;
            OFF_CHG_A:     reg_id = RID_CHG_A;
            OFF_CHG_B:     reg_id = RID_CHG_B;
            OFF_SOFT_RST:  reg_id = RID_SOFT_RST;
            OFF_MEM_STAT:  reg_id = RID_MEM_STAT;
            OFF_LINK_STAT: reg_id = RID_LINK_STAT;
            OFF_CLK_DIV:   reg_id = RID_CLK_DIV;
            OFF_BUILD_OPT: reg_id = RID_BUILD_OPT;
            OFF_MEM_CFG:   reg_id = RID_MEM_CFG;
            default:       reg_id = RID_NONE;
        endcase
    end

    // Classify which identifiers accept reads and which accept writes.
    always_comb begin
        rd_known = 1'b0;
        wr_known = 1'b0;
        case (reg_id)
            RID_BUILD_ID, RID_CHG_A, RID_CHG_B, RID_MEM_STAT,
            RID_CLK_DIV, RID_BUILD_OPT, RID_MEM_CFG: begin
                rd_known = 1'b1;
                wr_known = 1'b1;
            end
            RID_SOFT_RST, RID_LINK_STAT: begin
                wr_known = 1'b1;
            end
            default: begin
                rd_known = 1'b0;
                wr_known = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sysinfo_values.sv
// Read-value source: builds each readable status word from constants and
// elaboration parameters. Assumes INPUT_MHZ fits 8 bits and MEM_GIB 4 bits.
module sysinfo_values
    import sysinfo_pkg::*;
#(
    parameter int INPUT_MHZ = 100,
    parameter int MEM_GIB   = 1
) (
    input  reg_id_e           reg_id,
    output logic [DATA_W-1:0] value
);

    localparam int         DIV_FIELDS = 4;
    localparam logic [7:0] MHZ8       = 8'(INPUT_MHZ);
    localparam logic [3:0] GIB4       = 4'(MEM_GIB);
    localparam logic [7:0] DIV_FIELD [DIV_FIELDS] = '{8'd1, MHZ8, 8'd1, 8'd1};

    logic [DATA_W-1:0] div_word;
    logic [DATA_W-1:0] mem_cfg_word;

    // Pack one byte-wide divider field per lane.
    for (genvar g = 0; g < DIV_FIELDS; g++) begin : g_div
        assign div_word[8*g +: 8] = DIV_FIELD[g];
    end

    // Memory size in the low nibble, all-ones speed field above it.
    assign mem_cfg_word = {16'h0000, 12'hFFF, GIB4};

    // Select the word for the addressed register.
    always_comb begin
        case (reg_id)
            RID_MEM_STAT:  value = 32'h0000_0005;
            RID_CLK_DIV:   value = div_word;
            RID_BUILD_OPT: value = 32'h0000_000E;
            RID_MEM_CFG:   value = mem_cfg_word;
            default:       value = '0;
        endcase
    end

endmodule

// File: rtl/sysinfo_rstreq.sv
// Reset-request generator: registers a single-cycle pulse when a qualified
// soft-reset write carries the trigger bit. Synchronous active-low reset.
module sysinfo_rstreq (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic trig_bit,
    output logic req
);

    // Pulse for the one cycle after the qualifying write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else begin
            req <= fire & trig_bit;
        end
    end

endmodule

// File: rtl/sysinfo_regs.sv
// Board status and soft-reset register block. Decodes the low 16 address
// bits, honours only 4-byte accesses, returns registered read data one cycle
// after the strobe and flags wrong sizes or unknown offsets for one cycle.
// Assumes single-cycle strobes and a synchronous active-low reset.
module sysinfo_regs
    import sysinfo_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int INPUT_MHZ = 100,
    parameter int MEM_GIB   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [3:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bad_access,
    output logic              sys_reset_req
);

    reg_id_e           reg_id;
    logic              rd_known;
    logic              wr_known;
    logic              full_word;
    logic              rd_ok;
    logic              wr_ok;
    logic              rst_fire;
    logic [DATA_W-1:0] rd_value;
    logic              unused_bits;

    assign unused_bits = ^{bus_addr[ADDR_W-1:OFF_W], bus_wdata};

    sysinfo_decode u_decode (
        .offset   (bus_addr[OFF_W-1:0]),
        .reg_id   (reg_id),
        .rd_known (rd_known),
        .wr_known (wr_known)
    );

    sysinfo_values #(
        .INPUT_MHZ (INPUT_MHZ),
        .MEM_GIB   (MEM_GIB)
    ) u_values (
        .reg_id (reg_id),
        .value  (rd_value)
    );

    assign full_word = (bus_size == 4'(FULL_SZ));
    assign rd_ok     = bus_rd & full_word & rd_known;
    assign wr_ok     = bus_wr & full_word & wr_known;
    assign rst_fire  = wr_ok & (reg_id == RID_SOFT_RST);

    sysinfo_rstreq u_rstreq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (rst_fire),
        .trig_bit (bus_wdata[RST_BIT]),
        .req      (sys_reset_req)
    );

    // Register read data and the unsupported-access flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bad_access <= 1'b0;
        end else begin
            bus_rdata  <= rd_ok ? rd_value : '0;
            bad_access <= (bus_rd & ~rd_ok) | (bus_wr & ~wr_ok);
        end
    end

endmodule

// File: rtl/sysinfo_regs_chk.sv
// Checker for the board status block, attached by bind. Relates the bus
// strobes of one cycle to the outputs of the next.
module sysinfo_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] chk_off,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [3:0]  bus_size,
    input logic        chk_trig,
    input logic [31:0] bus_rdata,
    input logic        bad_access,
    input logic        sys_reset_req
);

    // R9
    rst_req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(bus_wr && bus_size == 4'd4 && chk_off == 16'h0010 && chk_trig));

    // R9
    rst_req_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && bus_size == 4'd4 && chk_off == 16'h0010 && chk_trig) |-> sys_reset_req);

    // R2
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> bus_rdata == 32'h0);

    // R10
    bad_size_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && bus_size != 4'd4) |-> (bus_rdata == 32'h0 && bad_access));

    // R5
    mem_status_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && bus_size == 4'd4 && chk_off == 16'h0014) |-> bus_rdata == 32'h5);

    // R11
    flag_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> $past(bus_rd || bus_wr));

endmodule

bind sysinfo_regs sysinfo_regs_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .chk_off       (bus_addr[15:0]),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_size      (bus_size),
    .chk_trig      (bus_wdata[4]),
    .bus_rdata     (bus_rdata),
    .bad_access    (bad_access),
    .sys_reset_req (sys_reset_req)
);

// File: tb/sysinfo_regs_test.sv
// Bench: a vector table walked by one loop, then directed reset and timing tests.
module sysinfo_regs_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 23;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic [3:0]  sz;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [31:0] exp_rd;
        logic        exp_bad;
        logic        exp_req;
        logic [3:0]  req;
    } vec_t;

    // Built with INPUT_MHZ=50 and MEM_GIB=2: divider 0x01013201, memory cfg 0x0000FFF2.
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 4'd4, 32'h0000_0000, 32'h0, 32'h0000_0000, 1'b0, 1'b0, 4'd4},  // R4
        '{1'b1, 1'b0, 4'd4, 32'h0000_0004, 32'h0, 32'h0000_0000, 1'b0, 1'b0, 4'd4},  // R4
        '{1'b1, 1'b0, 4'd4, 32'h0000_0008, 32'h0, 32'h0000_0000, 1'b0, 1'b0, 4'd4},  // R4
        '{1'b1, 1'b0, 4'd4, 32'h0000_0014, 32'h0, 32'h0000_0005, 1'b0, 1'b0, 4'd5},  // R5
        '{1'b1, 1'b0, 4'd4, 32'h0000_0030, 32'h0, 32'h0101_3201, 1'b0, 1'b0, 4'd6},  // R6
        '{1'b1, 1'b0, 4'd4, 32'h0000_0034, 32'h0, 32'h0000_000E, 1'b0, 1'b0, 4'd7},  // R7
        '{1'b1, 1'b0, 4'd4, 32'h0000_0038, 32'h0, 32'h0000_FFF2, 1'b0, 1'b0, 4'd8},  // R8
        '{1'b1, 1'b0, 4'd4, 32'h1234_0038, 32'h0, 32'h0000_FFF2, 1'b0, 1'b0, 4'd3},  // R3
        '{1'b1, 1'b0, 4'd2, 32'h0000_0014, 32'h0, 32'h0000_0000, 1'b1, 1'b0, 4'd10}, // R10
        '{1'b1, 1'b0, 4'd8, 32'h0000_0030, 32'h0, 32'h0000_0000, 1'b1, 1'b0, 4'd10}, // R10
        '{1'b1, 1'b0, 4'd4, 32'h0000_000C, 32'h0, 32'h0000_0000, 1'b1, 1'b0, 4'd11}, // R11
        '{1'b1, 1'b0, 4'd4, 32'h0000_0018, 32'h0, 32'h0000_0000, 1'b1, 1'b0, 4'd11}, // R11
        '{1'b1, 1'b0, 4'd4, 32'h0000_0048, 32'h0, 32'h0000_0000, 1'b1, 1'b0, 4'd11}, // R11
        '{1'b1, 1'b0, 4'd4, 32'h0000_0016, 32'h0, 32'h0000_0000, 1'b1, 1'b0, 4'd11}, // R11
        '{1'b0, 1'b1, 4'd4, 32'h0000_0010, 32'h10, 32'h0, 1'b0, 1'b1, 4'd9},         // R9
        '{1'b0, 1'b1, 4'd4, 32'h0000_0010, 32'hEF, 32'h0, 1'b0, 1'b0, 4'd9},         // R9
        '{1'b0, 1'b1, 4'd1, 32'h0000_0010, 32'h10, 32'h0, 1'b1, 1'b0, 4'd10},        // R10
        '{1'b0, 1'b1, 4'd4, 32'h0000_0030, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 4'd12}, // R12
        '{1'b1, 1'b0, 4'd4, 32'h0000_0030, 32'h0, 32'h0101_3201, 1'b0, 1'b0, 4'd12}, // R12
        '{1'b0, 1'b1, 4'd4, 32'h0000_001C, 32'h10, 32'h0, 1'b1, 1'b0, 4'd12},        // R12
        '{1'b0, 1'b1, 4'd4, 32'h5555_0010, 32'h10, 32'h0, 1'b0, 1'b1, 4'd3},         // R3
        '{1'b0, 1'b1, 4'd4, 32'h0000_0014, 32'h0, 32'h0, 1'b0, 1'b0, 4'd12},         // R12
        '{1'b1, 1'b0, 4'd4, 32'h0000_0014, 32'h0, 32'h0000_0005, 1'b0, 1'b0, 4'd12}  // R12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bad_access;
    logic        sys_reset_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysinfo_regs #(
        .ADDR_W    (32),
        .INPUT_MHZ (50),
        .MEM_GIB   (2)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_rd        (bus_rd),
        .bus_wr        (bus_wr),
        .bus_size      (bus_size),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .bad_access    (bad_access),
        .sys_reset_req (sys_reset_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one access at a falling edge, return at the next falling edge.
    task automatic access(input logic rd, input logic wr, input logic [3:0] sz,
                          input logic [31:0] addr, input logic [31:0] wd);
        bus_rd = rd; bus_wr = wr; bus_size = sz; bus_addr = addr; bus_wdata = wd;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_size = '0; bus_addr = '0; bus_wdata = '0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet while reset is held
        check("R1 rdata in reset", bus_rdata, 32'h0);
        check("R1 flag in reset", {31'h0, bad_access}, 32'h0);
        check("R1 reset req in reset", {31'h0, sys_reset_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata after reset", bus_rdata, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            access(VECS[i].rd, VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].wd);
            check($sformatf("R%0d rdata vec %0d", VECS[i].req, i), bus_rdata, VECS[i].exp_rd);
            check($sformatf("R%0d flag vec %0d", VECS[i].req, i), {31'h0, bad_access}, {31'h0, VECS[i].exp_bad});
            check($sformatf("R%0d reset req vec %0d", VECS[i].req, i), {31'h0, sys_reset_req}, {31'h0, VECS[i].exp_req});
        end

        // R2: data only in the cycle after the read strobe
        access(1'b1, 1'b0, 4'd4, 32'h34, 32'h0);
        check("R2 data one cycle after strobe", bus_rdata, 32'h0000_000E);
        @(negedge clk);
        check("R2 data cleared when idle", bus_rdata, 32'h0);

        // R9: request lasts exactly one cycle
        access(1'b0, 1'b1, 4'd4, 32'h10, 32'hFFFF_FFFF);
        check("R9 request raised", {31'h0, sys_reset_req}, 32'h1);
        @(negedge clk);
        check("R9 request single cycle", {31'h0, sys_reset_req}, 32'h0);

        // R10: flag lasts one cycle
        access(1'b1, 1'b0, 4'd1, 32'h0, 32'h0);
        check("R10 flag raised", {31'h0, bad_access}, 32'h1);
        @(negedge clk);
        check("R10 flag single cycle", {31'h0, bad_access}, 32'h0);

        // R1: reset mid-run clears outputs
        bus_rd = 1'b1; bus_size = 4'd4; bus_addr = 32'h30;
        rst_n = 1'b0;
        @(negedge clk);
        bus_rd = 1'b0; bus_size = '0; bus_addr = '0;
        check("R1 rdata cleared by reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule